// File: doc/BRIEF.md
# Quad-Channel Serial Converter Input Controller

This block is the digital front end of a four-channel 8-bit converter. A host sends 16-bit command words over a serial port made of an active-low select, a frame sync, a serial clock and a data line. All of these pins are brought into the block's own system clock through two-flop synchronisers, and edges are found by comparing each synchronised level with its value one cycle earlier. A word names one channel with two address bits. It carries that channel's power-down flag, its settling-speed flag and an 8-bit code. The code goes first into a holding register and, under control of an active-low load pin, into the output register that drives the converter.

For a three-wire link the select pin is tied low. With the load pin held low, each word updates its channel's output at once. With the load pin held high, several channels can be loaded into their holding registers, and a single low level on the load pin then moves all four holding registers to the outputs together. The flags take effect at the commit of the word that carries them, whatever the load pin does.

Top module: `quad_dac_frontend`

## Requirements
- R1: While the select input is high, edges on the frame sync and the serial clock are ignored: no holding register, output register or flag changes.
- R2: A frame-sync falling edge with select low starts a frame and clears the bit counter. Data is sampled on each later serial-clock falling edge, most significant bit first.
- R3: Once 16 bits are captured, the first rising edge of either the serial clock or the frame sync commits the word. Bits 15:14 select the channel (00 = channel 0, 01 = 1, 10 = 2, 11 = 3), and bits 11:4 are written into that channel's holding register. Bits 3:0 are unused.
- R4: At commit, word bit 13 becomes the addressed channel's power-down flag (1 = powered down) and bit 12 its speed flag (1 = fast settling, 0 = slow), independent of the load input.
- R5: If the load input is low when a word commits, the addressed channel's output code takes the new value.
- R6: While the load input is high the output codes hold. While it is low every output code follows its holding register, so a high-to-low transition copies all four at once.
- R7: If select rises before the 16th bit, the partial frame is dropped, no register changes, and the next complete frame is received correctly.
- R8: After reset all holding and output codes are zero, every channel is powered down, and every speed flag is slow.
- R9: Frames arriving back to back with an 800 ns period (1.25 MHz update rate) are each committed to their own channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Active-low select; tie low for three-wire use |
| fsync_i | input | 1 | Frame sync; a falling edge opens a frame |
| sclk_i | input | 1 | Serial clock; data sampled on falling edges |
| sdata_i | input | 1 | Serial data, most significant bit first |
| load_n_i | input | 1 | Active-low output load control |
| code_o | output | 32 | Output codes, channel n in bits 8n+7:8n |
| pdown_o | output | 4 | Per-channel power-down flags |
| fast_o | output | 4 | Per-channel fast-settling flags |

## Verification
A bit counter that drifts shows up as a wrong code or a wrong channel on the very next frame, because the address and code fields shift along with it. A lost partial-frame discard shows as a corrupted channel only after the following frame commits. A holding register that is wrong stays hidden at the ports while the load pin is high, and appears on the output codes a few system cycles after the load pin falls. That is why the bench loads words with the load pin high and then releases it. Flag errors appear at the ports within a few cycles of the commit edge.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

    localparam int FRAME_BITS = 16;
    localparam int CODE_W     = 8;
    localparam int ADDR_W     = 2;
    localparam int NUM_CH     = 1 << ADDR_W;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);

    // field positions inside a command word
    localparam int ADDR_MSB = FRAME_BITS - 1;
    localparam int PD_POS   = ADDR_MSB - ADDR_W;
    localparam int FAST_POS = PD_POS - 1;
    localparam int CODE_MSB = FAST_POS - 1;

    // synchronised pin bundle positions
    localparam int PIN_CS   = 4;
    localparam int PIN_FS   = 3;
    localparam int PIN_SCK  = 2;
    localparam int PIN_SDI  = 1;
    localparam int PIN_LOAD = 0;
    localparam int PIN_W    = 5;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              pdown;
        logic              fast;
        logic [CODE_W-1:0] code;
    } cmd_t;

endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
    parameter int              WIDTH   = 5,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] cur_o,
    output logic [WIDTH-1:0] prev_o
);

    // STAGES synchroniser flops plus one extra for edge detection
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0][WIDTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = raw_i;
        for (int i = 1; i < DEPTH; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= {DEPTH{RST_VAL}};
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign cur_o  = pipe_q[STAGES-1];
    assign prev_o = pipe_q[STAGES];

endmodule

// File: rtl/qdac_shift.sv
module qdac_shift
    import qdac_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs_low,
    input  logic                  fs_fall,
    input  logic                  fs_rise,
    input  logic                  sck_fall,
    input  logic                  sck_rise,
    input  logic                  sdata,
    output logic                  commit,
    output logic [FRAME_BITS-1:0] word,
    output logic [CNT_W-1:0]      bit_cnt
);

    typedef struct packed {
        logic                  active;
        logic [CNT_W-1:0]      cnt;
        logic [FRAME_BITS-1:0] sr;
    } shift_st_t;

    shift_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        commit = 1'b0;
        if (!cs_low) begin
            st_d.active = 1'b0;
            st_d.cnt    = '0;
        end else if (fs_fall) begin
            st_d.active = 1'b1;
            st_d.cnt    = '0;
        end else if (st_q.active) begin
            if (st_q.cnt == CNT_W'(FRAME_BITS)) begin
                if (sck_rise || fs_rise) begin
                    commit      = 1'b1;
                    st_d.active = 1'b0;
                    st_d.cnt    = '0;
                end
            end else if (sck_fall) begin
                st_d.sr  = {st_q.sr[FRAME_BITS-2:0], sdata};
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word    = st_q.sr;
    assign bit_cnt = st_q.cnt;

endmodule

// File: rtl/qdac_regbank.sv
module qdac_regbank
    import qdac_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     commit,
    input  cmd_t                     cmd,
    input  logic                     load_low,
    output logic [NUM_CH*CODE_W-1:0] hold_flat,
    output logic [NUM_CH*CODE_W-1:0] code_flat,
    output logic [NUM_CH-1:0]        pdown,
    output logic [NUM_CH-1:0]        fast
);

    typedef struct packed {
        logic [NUM_CH-1:0][CODE_W-1:0] hold;
        logic [NUM_CH-1:0][CODE_W-1:0] out;
        logic [NUM_CH-1:0]             pd;
        logic [NUM_CH-1:0]             fs;
    } bank_st_t;

    bank_st_t bk_d, bk_q;

    always_comb begin
        bk_d = bk_q;
        if (commit) begin
            bk_d.hold[cmd.addr] = cmd.code;
            bk_d.pd[cmd.addr]   = cmd.pdown;
            bk_d.fs[cmd.addr]   = cmd.fast;
        end
        // level-sensitive transfer: includes a word committing this cycle
        if (load_low) begin
            bk_d.out = bk_d.hold;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bk_q.hold <= '0;
            bk_q.out  <= '0;
            bk_q.pd   <= '1;
            bk_q.fs   <= '0;
        end else begin
            bk_q <= bk_d;
        end
    end

    assign hold_flat = bk_q.hold;
    assign code_flat = bk_q.out;
    assign pdown     = bk_q.pd;
    assign fast      = bk_q.fs;

endmodule

// File: rtl/quad_dac_frontend.sv
module quad_dac_frontend
    import qdac_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cs_n_i,
    input  logic                     fsync_i,
    input  logic                     sclk_i,
    input  logic                     sdata_i,
    input  logic                     load_n_i,
    output logic [NUM_CH*CODE_W-1:0] code_o,
    output logic [NUM_CH-1:0]        pdown_o,
    output logic [NUM_CH-1:0]        fast_o
);

    localparam logic [PIN_W-1:0] PIN_IDLE = 5'b11101;

    logic [PIN_W-1:0]      pin_raw, pin_cur, pin_prev;
    logic                  cs_low, load_low;
    logic                  fs_fall, fs_rise, sck_fall, sck_rise;
    logic                  commit;
    logic [FRAME_BITS-1:0] word;
    logic [CNT_W-1:0]      bit_cnt;
    cmd_t                  cmd;
    logic [NUM_CH*CODE_W-1:0] hold_flat;

    always_comb begin
        pin_raw           = '0;
        pin_raw[PIN_CS]   = cs_n_i;
        pin_raw[PIN_FS]   = fsync_i;
        pin_raw[PIN_SCK]  = sclk_i;
        pin_raw[PIN_SDI]  = sdata_i;
        pin_raw[PIN_LOAD] = load_n_i;
    end

    qdac_sync #(
        .WIDTH   (PIN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_IDLE)
    ) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (pin_raw),
        .cur_o  (pin_cur),
        .prev_o (pin_prev)
    );

    assign cs_low   = ~pin_cur[PIN_CS];
    assign load_low = ~pin_cur[PIN_LOAD];
    assign fs_fall  =  pin_prev[PIN_FS]  & ~pin_cur[PIN_FS];
    assign fs_rise  = ~pin_prev[PIN_FS]  &  pin_cur[PIN_FS];
    assign sck_fall =  pin_prev[PIN_SCK] & ~pin_cur[PIN_SCK];
    assign sck_rise = ~pin_prev[PIN_SCK] &  pin_cur[PIN_SCK];

    qdac_shift i_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_low   (cs_low),
        .fs_fall  (fs_fall),
        .fs_rise  (fs_rise),
        .sck_fall (sck_fall),
        .sck_rise (sck_rise),
        .sdata    (pin_cur[PIN_SDI]),
        .commit   (commit),
        .word     (word),
        .bit_cnt  (bit_cnt)
    );

    always_comb begin
        cmd.addr  = word[ADDR_MSB -: ADDR_W];
        cmd.pdown = word[PD_POS];
        cmd.fast  = word[FAST_POS];
        cmd.code  = word[CODE_MSB -: CODE_W];
    end

    qdac_regbank i_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (commit),
        .cmd       (cmd),
        .load_low  (load_low),
        .hold_flat (hold_flat),
        .code_flat (code_o),
        .pdown     (pdown_o),
        .fast      (fast_o)
    );

endmodule

// File: rtl/qdac_checker.sv
module qdac_checker
    import qdac_pkg::*;
(
    input logic                     clk,
    input logic                     rst_n,
    input logic                     cs_low,
    input logic                     load_low,
    input logic                     commit,
    input logic [CNT_W-1:0]         bit_cnt,
    input logic [NUM_CH*CODE_W-1:0] hold_flat,
    input logic [NUM_CH*CODE_W-1:0] code_o,
    input logic [NUM_CH-1:0]        pdown_o,
    input logic [NUM_CH-1:0]        fast_o
);

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(FRAME_BITS)); // R2

    AST_COMMIT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> bit_cnt == CNT_W'(FRAME_BITS)); // R3

    AST_NO_COMMIT_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_low |-> !commit); // R1

    AST_DESELECT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_low |=> bit_cnt == '0); // R7

    AST_FLAGS_NEED_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(pdown_o) && $stable(fast_o)); // R4

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_low |=> $stable(code_o)); // R6

    AST_OUT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        load_low |=> code_o == hold_flat); // R5

endmodule

bind quad_dac_frontend qdac_checker i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_low    (cs_low),
    .load_low  (load_low),
    .commit    (commit),
    .bit_cnt   (bit_cnt),
    .hold_flat (hold_flat),
    .code_o    (code_o),
    .pdown_o   (pdown_o),
    .fast_o    (fast_o)
);

// File: tb/test_quad_dac_frontend.sv
module test_quad_dac_frontend;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n_i = 1'b0;
    logic        fsync_i = 1'b1;
    logic        sclk_i = 1'b1;
    logic        sdata_i = 1'b0;
    logic        load_n_i = 1'b0;
    logic [31:0] code_o;
    logic [3:0]  pdown_o, fast_o;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk; // 125 MHz

    quad_dac_frontend i_quad_dac_frontend (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n_i   (cs_n_i),
        .fsync_i  (fsync_i),
        .sclk_i   (sclk_i),
        .sdata_i  (sdata_i),
        .load_n_i (load_n_i),
        .code_o   (code_o),
        .pdown_o  (pdown_o),
        .fast_o   (fast_o)
    );

    typedef struct {
        string       tag;
        logic [31:0] code;
        logic [3:0]  pd;
        logic [3:0]  fs;
    } exp_t;

    exp_t       sb_q[$];
    logic [7:0] hold_m[4];
    logic [7:0] out_m[4];
    logic [3:0] pd_m = 4'hF;
    logic [3:0] fast_m = 4'h0;

    task automatic push(input string tag);
        exp_t e;
        e.tag = tag;
        for (int c = 0; c < 4; c++) e.code[c*8 +: 8] = out_m[c];
        e.pd = pd_m;
        e.fs = fast_m;
        sb_q.push_back(e);
    endtask

    // mode 0: commit on serial-clock rise, 1: commit on frame-sync rise,
    // 2: whole frame sent with select high (must be ignored)
    task automatic send_frame(input logic [1:0] a, input logic pd, input logic fs,
                              input logic [7:0] c, input int mode, input string tag);
        logic [15:0] w;
        w = {a, pd, fs, c, 4'b0000};
        @(negedge clk); #1;
        if (mode == 2) cs_n_i = 1'b1;
        fsync_i = 1'b0;
        #20;
        for (int i = 15; i >= 0; i--) begin
            sdata_i = w[i];
            #20 sclk_i = 1'b0;
            if (i == 0 && mode == 1) begin
                #20 fsync_i = 1'b1;
                #20 sclk_i = 1'b1;
            end else begin
                #20 sclk_i = 1'b1;
            end
        end
        if (mode != 1) begin
            #20 fsync_i = 1'b1;
        end
        #120;
        cs_n_i = 1'b0;
        if (mode != 2) begin
            hold_m[a] = c;
            pd_m[a]   = pd;
            fast_m[a] = fs;
            if (!load_n_i) for (int k = 0; k < 4; k++) out_m[k] = hold_m[k];
        end
        push(tag);
    endtask

    task automatic partial_frame(input logic [1:0] a, input logic [7:0] c, input int nbits);
        logic [15:0] w;
        w = {a, 2'b11, c, 4'b0000};
        @(negedge clk); #1;
        fsync_i = 1'b0;
        #20;
        for (int i = 15; i > 15 - nbits; i--) begin
            sdata_i = w[i];
            #20 sclk_i = 1'b0;
            #20 sclk_i = 1'b1;
        end
        cs_n_i = 1'b1;
        #40 fsync_i = 1'b1;
        #40 cs_n_i = 1'b0;
        #80;
        push("R7 partial frame discarded");
    endtask

    task automatic set_load(input logic v, input string tag);
        @(negedge clk); #1;
        load_n_i = v;
        repeat (8) @(negedge clk);
        if (!v) for (int k = 0; k < 4; k++) out_m[k] = hold_m[k];
        push(tag);
    endtask

    // monitor: compare expected items against the ports
    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            if (sb_q.size() > 0) begin
                e = sb_q.pop_front();
                checks++;
                if (code_o !== e.code) begin
                    fails++;
                    $display("FAIL %s codes: actual %h expected %h", e.tag, code_o, e.code);
                end
                checks++;
                if (pdown_o !== e.pd) begin
                    fails++;
                    $display("FAIL %s power-down: actual %b expected %b", e.tag, pdown_o, e.pd);
                end
                checks++;
                if (fast_o !== e.fs) begin
                    fails++;
                    $display("FAIL %s speed: actual %b expected %b", e.tag, fast_o, e.fs);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int k = 0; k < 4; k++) begin
            hold_m[k] = 8'h00;
            out_m[k]  = 8'h00;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        push("R8 reset state");

        // immediate load, MSB-first capture, flags
        send_frame(2'd0, 1'b0, 1'b1, 8'hA5, 0, "R2 R3 R4 R5 channel 0");
        // back-to-back frames at an 800 ns period
        send_frame(2'd1, 1'b0, 1'b0, 8'h5A, 0, "R9 R3 channel 1");
        send_frame(2'd2, 1'b1, 1'b1, 8'hC3, 0, "R9 R4 channel 2");
        send_frame(2'd3, 1'b0, 1'b1, 8'h81, 0, "R9 R3 channel 3");
        // commit by frame-sync rise, later clock rise ignored
        send_frame(2'd0, 1'b1, 1'b0, 8'h18, 1, "R3 frame-sync commit");
        // deselected frame ignored
        send_frame(2'd1, 1'b1, 1'b1, 8'hEE, 2, "R1 select high");
        // partial frame then a good frame on the same channel
        partial_frame(2'd2, 8'h3F, 9);
        send_frame(2'd2, 1'b0, 1'b0, 8'h7E, 0, "R7 R2 frame after discard");
        // deferred load
        set_load(1'b1, "R6 load high no change");
        send_frame(2'd0, 1'b0, 1'b1, 8'h3C, 0, "R6 R4 held output channel 0");
        send_frame(2'd3, 1'b1, 1'b0, 8'h12, 0, "R6 held output channel 3");
        set_load(1'b0, "R6 load low copies all");
        send_frame(2'd1, 1'b0, 1'b1, 8'h01, 0, "R5 immediate update channel 1");

        wait (sb_q.size() == 0);
        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule